// File: doc/BRIEF.md
# CAN Status and Error-Warning Register Unit

This unit holds the status and error-warning registers that software sees in a CAN controller with three transmit buffers. It stores a programmable 8-bit warning limit and compares it with the transmit and receive error counters. When either counter reaches the limit, an error-status flag is set. Each change of that flag raises a one-cycle warning interrupt, which an enable input can mask.

The unit also assembles a status word with one byte per transmit buffer. Each byte shows whether its buffer is released or locked and whether that buffer's last transmission completed. It also repeats the global receive flags and the error-status flag. The unit guards the transmit frame registers of every buffer, so software cannot overwrite a frame that is waiting to be sent or is being sent.

Reset mode gates both the limit and the flag. The limit can only be written while reset mode is active. The error-status flag is frozen while reset mode is active, so a new limit shows its effect only after reset mode is left. On the first cycle outside reset mode, the unit evaluates the flag again and raises the interrupt if the flag changed.

Top module: `can_status_warn`

## Requirements
- R1: After reset the warning limit reads 96 (0x60), the error-status flag and the interrupt are 0, and every buffer reads released (status bit 2 = 1) and complete (status bit 3 = 1).
- R2: A bus write to address 0 updates the limit only while resetMode is 1. At all other times the write is ignored and the old limit reads back.
- R3: Reading address 0 returns the limit in bits 7:0, with all higher bits 0, whatever the mode.
- R4: Outside reset mode the error-status flag (output errStat) becomes 1 one cycle after txErrCnt or rxErrCnt is greater than or equal to the limit. It becomes 0 one cycle after both counters are below the limit.
- R5: While resetMode is 1 the error-status flag holds its value and no interrupt is raised. On the first clock edge after resetMode returns to 0, the flag is evaluated again against the current counters and the current limit.
- R6: warnIrq is 1 for exactly one cycle, in the same cycle that errStat changes value outside reset mode, provided intEn was 1 at that edge. warnIrq stays 0 when intEn is 0.
- R7: Address 1 returns the status word, where byte k belongs to buffer k. The bit layout is: bit 0 receive buffer status, bit 1 data overrun, bit 2 buffer released, bit 3 transmission complete, bit 4 receive status, bit 6 error status. Bits 5 and 7 are 0.
- R8: A txReq pulse on a released buffer locks it and clears its complete bit. A txStart pulse then marks it as sending. A txDone pulse while sending releases the buffer and sets its complete bit. txDone before txStart is ignored, and txReq on a locked buffer is ignored.
- R9: Frame word w of buffer k is at address 4 + 4*k + w and reads back at any time. A write to it is accepted only while buffer k is released. While the buffer is locked, a write leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W (4) | Register word address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Read data of the addressed register, combinational |
| resetMode | input | 1 | Controller reset-mode bit |
| intEn | input | 1 | Warning interrupt enable |
| txErrCnt | input | CNT_W (8) | Transmit error counter |
| rxErrCnt | input | CNT_W (8) | Receive error counter |
| rxBufStat | input | 1 | Global receive buffer status |
| dataOverrun | input | 1 | Global data overrun status |
| rxStat | input | 1 | Global receive status |
| txReq | input | NUM_TXBUF (3) | Per-buffer transmission request pulse |
| txStart | input | NUM_TXBUF (3) | Per-buffer transmission start pulse |
| txDone | input | NUM_TXBUF (3) | Per-buffer successful completion pulse |
| errStat | output | 1 | Error-status flag |
| warnIrq | output | 1 | Error-warning interrupt pulse |

## Verification
The bench builds the unit with its default parameters: three transmit buffers of four frame words, 8-bit counters and a reset limit of 96. With three buffers, each status byte can show a different buffer state at the same time, and address decoding reaches the last frame word of the last buffer. With 8-bit counters, the bench can place each counter exactly at the limit and one below it, on both the transmit and receive sides. A limit written during reset mode is then checked for its deferred effect when reset mode is left.

// File: rtl/csw_pkg.sv
package csw_pkg;

  localparam int IDX_W = 8;

  // bit positions inside one status byte
  localparam int ST_RXBUF  = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_TXFREE = 2;
  localparam int ST_TXDONE = 3;
  localparam int ST_RXACT  = 4;
  localparam int ST_ERR    = 6;

  typedef enum logic [1:0] {
    BUF_FREE = 2'd0,
    BUF_PEND = 2'd1,
    BUF_SEND = 2'd2
  } bufState_e;

  typedef struct packed {
    logic             limitWe;
    logic             frameWe;
    logic [IDX_W-1:0] frameBuf;
    logic [IDX_W-1:0] frameWord;
  } strobe_t;

endpackage

// File: rtl/csw_ctrl.sv
module csw_ctrl
  import csw_pkg::*;
#(
  parameter int NUM_TXBUF   = 3,
  parameter int FRAME_WORDS = 4,
  parameter int FRAME_BASE  = 4,
  parameter int ADDR_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic                 resetMode,
  input  logic [NUM_TXBUF-1:0] txReq,
  input  logic [NUM_TXBUF-1:0] txStart,
  input  logic [NUM_TXBUF-1:0] txDone,
  output strobe_t              strobe,
  output logic [NUM_TXBUF-1:0] bufReleased,
  output logic [NUM_TXBUF-1:0] txComplete
);

  localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(0);

  // bus decode into strobes for the datapath
  always_comb begin
    strobe = '0;
    strobe.limitWe = regWrEn && (regAddr == ADDR_LIMIT) && resetMode;
    for (int b = 0; b < NUM_TXBUF; b++) begin
      for (int w = 0; w < FRAME_WORDS; w++) begin
        if (regWrEn && bufReleased[b] &&
            (int'(regAddr) == FRAME_BASE + b * FRAME_WORDS + w)) begin
          strobe.frameWe   = 1'b1;
          strobe.frameBuf  = IDX_W'(b);
          strobe.frameWord = IDX_W'(w);
        end
      end
    end
  end

  // per-buffer lock / completion sequencing
  for (genvar b = 0; b < NUM_TXBUF; b++) begin : g_buf
    bufState_e stQ;
    logic      doneQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ   <= BUF_FREE;
        doneQ <= 1'b1;
      end else begin
        unique case (stQ)
          BUF_FREE: if (txReq[b]) begin
            stQ   <= BUF_PEND;
            doneQ <= 1'b0;
          end
          BUF_PEND: if (txStart[b]) stQ <= BUF_SEND;
          BUF_SEND: if (txDone[b]) begin
            stQ   <= BUF_FREE;
            doneQ <= 1'b1;
          end
          default: stQ <= BUF_FREE;
        endcase
      end
    end

    assign bufReleased[b] = (stQ == BUF_FREE);
    assign txComplete[b]  = doneQ;

    p_req_locks_r8: assert property (@(posedge clk) disable iff (!rstN)
      (bufReleased[b] && txReq[b]) |=> (!bufReleased[b] && !txComplete[b]));

    p_done_releases_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == BUF_SEND && txDone[b]) |=> (bufReleased[b] && txComplete[b]));

    p_early_done_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == BUF_PEND && !txStart[b]) |=> !bufReleased[b]);

    p_locked_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.frameWe && strobe.frameBuf == IDX_W'(b)) |-> (stQ == BUF_FREE));
  end

  p_limit_we_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.limitWe |-> resetMode);

endmodule

// File: rtl/csw_dpath.sv
module csw_dpath
  import csw_pkg::*;
#(
  parameter int NUM_TXBUF   = 3,
  parameter int FRAME_WORDS = 4,
  parameter int FRAME_BASE  = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int LIMIT_RST   = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 resetMode,
  input  logic                 intEn,
  input  logic [CNT_W-1:0]     txErrCnt,
  input  logic [CNT_W-1:0]     rxErrCnt,
  input  logic                 rxBufStat,
  input  logic                 dataOverrun,
  input  logic                 rxStat,
  input  logic [NUM_TXBUF-1:0] bufReleased,
  input  logic [NUM_TXBUF-1:0] txComplete,
  output logic                 errStat,
  output logic                 warnIrq
);

  localparam int ENTRIES = NUM_TXBUF * FRAME_WORDS;
  localparam int STAT_W  = 8 * NUM_TXBUF;

  logic [CNT_W-1:0]  limitQ;
  logic              esQ;
  logic              irqQ;
  logic              cmpHit;
  logic [STAT_W-1:0] statusWord;
  logic [DATA_W-1:0] frameMem [ENTRIES];

  // warning limit: writable only through the mode-gated strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) limitQ <= CNT_W'(LIMIT_RST);
    else if (strobe.limitWe) limitQ <= regWrData[CNT_W-1:0];
  end

  assign cmpHit = (txErrCnt >= limitQ) || (rxErrCnt >= limitQ);

  // error status frozen in reset mode; first normal edge re-evaluates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      esQ  <= 1'b0;
      irqQ <= 1'b0;
    end else if (resetMode) begin
      irqQ <= 1'b0;
    end else begin
      esQ  <= cmpHit;
      irqQ <= intEn && (cmpHit != esQ);
    end
  end

  assign errStat = esQ;
  assign warnIrq = irqQ;

  // transmit frame storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) frameMem[e] <= '0;
    end else if (strobe.frameWe) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (int'(strobe.frameBuf) * FRAME_WORDS + int'(strobe.frameWord) == e)
          frameMem[e] <= regWrData;
      end
    end
  end

  // status word, one byte per buffer
  always_comb begin
    statusWord = '0;
    for (int b = 0; b < NUM_TXBUF; b++) begin
      statusWord[8*b + ST_RXBUF]  = rxBufStat;
      statusWord[8*b + ST_OVR]    = dataOverrun;
      statusWord[8*b + ST_TXFREE] = bufReleased[b];
      statusWord[8*b + ST_TXDONE] = txComplete[b];
      statusWord[8*b + ST_RXACT]  = rxStat;
      statusWord[8*b + ST_ERR]    = esQ;
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(0)) regRdData = DATA_W'(limitQ);
    else if (regAddr == ADDR_W'(1)) regRdData = DATA_W'(statusWord);
    for (int e = 0; e < ENTRIES; e++) begin
      if (int'(regAddr) == FRAME_BASE + e) regRdData = frameMem[e];
    end
  end

  p_limit_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !resetMode |=> $stable(limitQ));

  p_es_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    resetMode |=> ($stable(esQ) && !irqQ));

  p_irq_needs_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> (esQ != $past(esQ)));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |=> !irqQ);

endmodule

// File: rtl/can_status_warn.sv
module can_status_warn
  import csw_pkg::*;
#(
  parameter int NUM_TXBUF   = 3,
  parameter int FRAME_WORDS = 4,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int LIMIT_RST   = 96,
  localparam int FRAME_BASE = 4,
  localparam int ADDR_W     = $clog2(FRAME_BASE + NUM_TXBUF * FRAME_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 resetMode,
  input  logic                 intEn,
  input  logic [CNT_W-1:0]     txErrCnt,
  input  logic [CNT_W-1:0]     rxErrCnt,
  input  logic                 rxBufStat,
  input  logic                 dataOverrun,
  input  logic                 rxStat,
  input  logic [NUM_TXBUF-1:0] txReq,
  input  logic [NUM_TXBUF-1:0] txStart,
  input  logic [NUM_TXBUF-1:0] txDone,
  output logic                 errStat,
  output logic                 warnIrq
);

  strobe_t              strobe;
  logic [NUM_TXBUF-1:0] bufReleased;
  logic [NUM_TXBUF-1:0] txComplete;

  csw_ctrl #(
    .NUM_TXBUF  (NUM_TXBUF),
    .FRAME_WORDS(FRAME_WORDS),
    .FRAME_BASE (FRAME_BASE),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .resetMode  (resetMode),
    .txReq      (txReq),
    .txStart    (txStart),
    .txDone     (txDone),
    .strobe     (strobe),
    .bufReleased(bufReleased),
    .txComplete (txComplete)
  );

  csw_dpath #(
    .NUM_TXBUF  (NUM_TXBUF),
    .FRAME_WORDS(FRAME_WORDS),
    .FRAME_BASE (FRAME_BASE),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .LIMIT_RST  (LIMIT_RST)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .resetMode  (resetMode),
    .intEn      (intEn),
    .txErrCnt   (txErrCnt),
    .rxErrCnt   (rxErrCnt),
    .rxBufStat  (rxBufStat),
    .dataOverrun(dataOverrun),
    .rxStat     (rxStat),
    .bufReleased(bufReleased),
    .txComplete (txComplete),
    .errStat    (errStat),
    .warnIrq    (warnIrq)
  );

endmodule

// File: tb/can_status_warn_tb.sv
module can_status_warn_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        resetMode = 1'b0;
  logic        intEn = 1'b0;
  logic [7:0]  txErrCnt = '0;
  logic [7:0]  rxErrCnt = '0;
  logic        rxBufStat = 1'b0;
  logic        dataOverrun = 1'b0;
  logic        rxStat = 1'b0;
  logic [2:0]  txReq = '0;
  logic [2:0]  txStart = '0;
  logic [2:0]  txDone = '0;
  logic        errStat;
  logic        warnIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  can_status_warn u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .resetMode(resetMode),
    .intEn(intEn), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .rxBufStat(rxBufStat), .dataOverrun(dataOverrun), .rxStat(rxStat),
    .txReq(txReq), .txStart(txStart), .txDone(txDone),
    .errStat(errStat), .warnIrq(warnIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // advance one edge; inputs change 2 ns after the edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] expStatus(input logic es, input logic [2:0] rel,
                                            input logic [2:0] cmp);
    logic [31:0] s = '0;
    for (int b = 0; b < 3; b++) begin
      s[8*b + 0] = rxBufStat;
      s[8*b + 1] = dataOverrun;
      s[8*b + 2] = rel[b];
      s[8*b + 3] = cmp[b];
      s[8*b + 4] = rxStat;
      s[8*b + 6] = es;
    end
    return s;
  endfunction

  task automatic pulse(input int which, input int b);
    if (which == 0) txReq[b] = 1'b1;
    else if (which == 1) txStart[b] = 1'b1;
    else txDone[b] = 1'b1;
    step();
    txReq = '0; txStart = '0; txDone = '0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    readReg(4'd0, d);
    check("R1 limit", d, 32'd96);
    readReg(4'd1, d);
    check("R1 status", d, expStatus(1'b0, 3'b111, 3'b111));
    check("R1 errStat", {31'd0, errStat}, 32'd0);
    check("R1 warnIrq", {31'd0, warnIrq}, 32'd0);
  endtask

  task automatic testLimitWrite();
    logic [31:0] d;
    resetMode = 1'b0;
    writeReg(4'd0, 32'd50);
    readReg(4'd0, d);
    check("R2 write outside reset ignored", d, 32'd96);
    resetMode = 1'b1;
    writeReg(4'd0, 32'hFFFF_FF32);
    readReg(4'd0, d);
    check("R3 limit readback masked", d, 32'h32);
    resetMode = 1'b0;
    step();
    readReg(4'd0, d);
    check("R3 limit readable in normal mode", d, 32'h32);
  endtask

  task automatic testCompare();
    logic [31:0] d;
    intEn = 1'b1;
    txErrCnt = 8'd49; rxErrCnt = 8'd0;
    step();
    check("R4 tx below limit", {31'd0, errStat}, 32'd0);
    txErrCnt = 8'd50;
    step();
    check("R4 tx equals limit", {31'd0, errStat}, 32'd1);
    check("R6 irq on set", {31'd0, warnIrq}, 32'd1);
    readReg(4'd1, d);
    check("R7 status shows error", d, expStatus(1'b1, 3'b111, 3'b111));
    txErrCnt = 8'd0; rxErrCnt = 8'd60;
    step();
    check("R4 rx above keeps flag", {31'd0, errStat}, 32'd1);
    check("R6 irq single cycle", {31'd0, warnIrq}, 32'd0);
    txErrCnt = 8'd49; rxErrCnt = 8'd49;
    step();
    check("R4 both below clears", {31'd0, errStat}, 32'd0);
    check("R6 irq on clear", {31'd0, warnIrq}, 32'd1);
    intEn = 1'b0;
    rxErrCnt = 8'd50;
    step();
    check("R4 rx equals limit", {31'd0, errStat}, 32'd1);
    check("R6 irq masked", {31'd0, warnIrq}, 32'd0);
    rxErrCnt = 8'd0; txErrCnt = 8'd0;
    step();
    check("R6 irq masked on clear", {31'd0, warnIrq}, 32'd0);
    check("R4 cleared again", {31'd0, errStat}, 32'd0);
  endtask

  task automatic testDeferred();
    intEn = 1'b1;
    resetMode = 1'b1;
    writeReg(4'd0, 32'd10);
    txErrCnt = 8'd20;
    step();
    step();
    check("R5 flag frozen in reset mode", {31'd0, errStat}, 32'd0);
    check("R5 no irq in reset mode", {31'd0, warnIrq}, 32'd0);
    resetMode = 1'b0;
    step();
    check("R5 re-evaluated on exit", {31'd0, errStat}, 32'd1);
    check("R5 deferred irq", {31'd0, warnIrq}, 32'd1);
    step();
    check("R6 deferred irq one cycle", {31'd0, warnIrq}, 32'd0);
    resetMode = 1'b1;
    txErrCnt = 8'd0;
    step();
    check("R5 set flag held in reset mode", {31'd0, errStat}, 32'd1);
    resetMode = 1'b0;
    step();
    check("R5 clear on exit", {31'd0, errStat}, 32'd0);
    check("R5 irq on exit clear", {31'd0, warnIrq}, 32'd1);
  endtask

  task automatic testStatusMirror();
    logic [31:0] d;
    rxBufStat = 1'b1; dataOverrun = 1'b0; rxStat = 1'b1;
    #1;
    readReg(4'd1, d);
    check("R7 mirror rbs/rs", d, 32'h001D1D1D);
    rxBufStat = 1'b0; dataOverrun = 1'b1; rxStat = 1'b0;
    readReg(4'd1, d);
    check("R7 mirror overrun", d, 32'h000E0E0E);
    dataOverrun = 1'b0;
  endtask

  task automatic testBuffers();
    logic [31:0] d;
    pulse(0, 1);
    readReg(4'd1, d);
    check("R8 request locks buf1", d, expStatus(1'b0, 3'b101, 3'b101));
    pulse(2, 1);
    readReg(4'd1, d);
    check("R8 done before start ignored", d, expStatus(1'b0, 3'b101, 3'b101));
    pulse(1, 1);
    pulse(0, 1);
    readReg(4'd1, d);
    check("R8 sending stays locked", d, expStatus(1'b0, 3'b101, 3'b101));
    pulse(2, 1);
    readReg(4'd1, d);
    check("R8 done releases buf1", d, expStatus(1'b0, 3'b111, 3'b111));
  endtask

  task automatic testFrames();
    logic [31:0] d;
    writeReg(4'd6, 32'hA5A5_0001);
    readReg(4'd6, d);
    check("R9 buf0 word2 write", d, 32'hA5A5_0001);
    pulse(0, 0);
    writeReg(4'd6, 32'h1234_5678);
    readReg(4'd6, d);
    check("R9 locked write ignored", d, 32'hA5A5_0001);
    writeReg(4'd15, 32'hCAFE_0015);
    readReg(4'd15, d);
    check("R9 buf2 last word writable", d, 32'hCAFE_0015);
    readReg(4'd1, d);
    check("R8 only buf0 locked", d, expStatus(1'b0, 3'b110, 3'b110));
    pulse(1, 0);
    pulse(2, 0);
    writeReg(4'd6, 32'h1234_5678);
    readReg(4'd6, d);
    check("R9 write after release", d, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    step();
    testReset();
    testLimitWrite();
    testCompare();
    testDeferred();
    testStatusMirror();
    testBuffers();
    testFrames();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule